// File: doc/BRIEF.md
# SD card SPI command engine

This block runs one command transaction of the SD card SPI protocol on top of a byte-wide SPI master. A requester hands over a 6-bit command index, a 32-bit argument, the CRC byte to send, a flag that asks for four trailing response bytes, and a flag that keeps the card selected afterwards. The engine pulls chip select low and sends the six-byte frame. It then clocks out idle bytes until the card answers with a byte whose top bit is clear. If the requester asked for them, it gathers the four bytes that follow into a 32-bit word. The shifting of single bits stays in the SPI master next to it.

When the transaction ends the engine returns the one-byte card status, the 32-bit trailer and a timeout flag, all together with a one-cycle done pulse. A normal transaction lets go of chip select and then sends one more idle byte so the card can release its data line. In keep-select mode a transaction that gets an answer leaves the card selected, so that a data phase can follow at once. Typical CRC values are 0x95 for the reset command and 0x87 for the interface-condition command.

Top module: `sd_cmd_engine`

## Requirements
- R1: The frame is six bytes sent in this order: first {2'b01, index} (0x40 OR index), then the argument with its most significant byte first, then the CRC byte exactly as the requester supplied it.
- R2: Chip select (active low) goes low in the cycle after a request is accepted and before the first frame byte. It stays low for every frame, poll and trailer byte.
- R3: After the frame the engine sends 0xFF and samples each received byte. A received byte with bit 7 set is skipped. The first byte with bit 7 clear is returned as the status byte.
- R4: If POLL_LIMIT poll bytes in a row have bit 7 set, the engine reports timeout=1 with status 0xFF. An answer that arrives on poll byte number POLL_LIMIT is still accepted, with timeout=0.
- R5: When the trailer is requested, the four bytes after the status byte are sent as 0xFF and are packed most significant first into the 32-bit trailer output. Without the request the trailer output reads 0.
- R6: A normal end drives chip select high, sends exactly one more 0xFF byte with chip select high, and then raises done for exactly one cycle.
- R7: In keep-select mode an answered command ends with chip select still low, sends no extra byte, and chip select stays low after done. On a timeout, keep-select mode ends the same way as R6.
- R8: Ready is high only while idle. It is low from the cycle after acceptance until done, and requests made while ready is low are ignored.
- R9: The engine only pulses spi_start for one cycle, and only when no byte is outstanding at the master.
- R10: After reset chip select is high, ready is high, and done and spi_start are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Engine is idle and will accept a request |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 8 | CRC byte sent as the last frame byte |
| req_trailer | input | 1 | Collect four trailing response bytes |
| req_keep_sel | input | 1 | Keep chip select low after an answered command |
| spi_tx | output | 8 | Byte for the SPI master to send |
| spi_start | output | 1 | One-cycle pulse that starts a byte transfer |
| spi_done | input | 1 | Master finished a byte, spi_rx is valid |
| spi_rx | input | 8 | Byte received by the master |
| spi_cs_n | output | 1 | Card chip select, active low |
| rsp_done | output | 1 | One-cycle pulse at the end of a transaction |
| rsp_r1 | output | 8 | Status byte, or 0xFF after a timeout |
| rsp_trail | output | 32 | Trailing response word |
| rsp_timeout | output | 1 | No answer within POLL_LIMIT poll bytes |

## Verification
The bench builds the engine with POLL_LIMIT set to 8 and TRAIL_EN set to 1. With these values a timeout takes only eight poll bytes, so both sides of the limit can be tested: an answer on the eighth poll byte, and no answer at all. Keeping the trailer path in the build lets the bench read a four-byte trailer and then show that the trailer output drops back to zero on a command that does not ask for one. A byte-level master model in the bench records every transmitted byte together with the chip-select level at that moment. This exposes the frame order, the release byte and keep-select mode directly.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
   localparam int BYTE_W      = 8;
   localparam int IDX_W       = 6;
   localparam int ARG_W       = 32;
   localparam int ARG_BYTES   = ARG_W / BYTE_W;
   localparam int FRAME_BYTES = ARG_BYTES + 2;
   localparam int TRAIL_BYTES = 4;
   localparam int TRAIL_W     = TRAIL_BYTES * BYTE_W;
   localparam int BIDX_W      = 3;
   localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_POLL,
      ST_TRAIL,
      ST_TAIL,
      ST_END
   } eng_state_e;
endpackage

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
   import sd_cmd_pkg::*;
(
   input  logic [IDX_W-1:0]  idx,
   input  logic [ARG_W-1:0]  arg,
   input  logic [BYTE_W-1:0] crc,
   input  logic [BIDX_W-1:0] sel,
   output logic [BYTE_W-1:0] byte_o
);
   always_comb begin
      byte_o = crc;
      if (sel == '0) begin
         byte_o = {2'b01, idx};
      end
      for (int k = 1; k <= ARG_BYTES; k++) begin
         if (sel == BIDX_W'(k)) begin
            byte_o = arg[ARG_W-BYTE_W*k +: BYTE_W];
         end
      end
   end
endmodule

// File: rtl/sd_poll_limit.sv
module sd_poll_limit #(
   parameter int LIMIT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sd_trail_shift.sv
module sd_trail_shift
   import sd_cmd_pkg::*;
#(
   parameter int NBYTES = TRAIL_BYTES
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     shift,
   input  logic [BYTE_W-1:0]        din,
   output logic [NBYTES*BYTE_W-1:0] word
);
   localparam int WW = NBYTES * BYTE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (clr) begin
         word <= '0;
      end else if (shift) begin
         word <= {word[WW-BYTE_W-1:0], din};
      end
   end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
   import sd_cmd_pkg::*;
#(
   parameter int POLL_LIMIT = 5000,
   parameter bit TRAIL_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [IDX_W-1:0]   req_index,
   input  logic [ARG_W-1:0]   req_arg,
   input  logic [BYTE_W-1:0]  req_crc,
   input  logic               req_trailer,
   input  logic               req_keep_sel,
   output logic [BYTE_W-1:0]  spi_tx,
   output logic               spi_start,
   input  logic               spi_done,
   input  logic [BYTE_W-1:0]  spi_rx,
   output logic               spi_cs_n,
   output logic               rsp_done,
   output logic [BYTE_W-1:0]  rsp_r1,
   output logic [TRAIL_W-1:0] rsp_trail,
   output logic               rsp_timeout
);
   localparam logic [BIDX_W-1:0] LAST_FRAME = BIDX_W'(FRAME_BYTES - 1);
   localparam logic [BIDX_W-1:0] LAST_TRAIL = BIDX_W'(TRAIL_BYTES - 1);

   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 1");
   end
   if (FRAME_BYTES > (1 << BIDX_W)) begin : g_bad_frame
      $error("byte index too narrow for frame");
   end

   eng_state_e          state_q;
   logic                wait_q;
   logic                cs_n_q;
   logic                keep_q;
   logic                trl_q;
   logic                tout_q;
   logic [BYTE_W-1:0]   r1_q;
   logic [BIDX_W-1:0]   bidx_q;
   logic [IDX_W-1:0]    idx_q;
   logic [ARG_W-1:0]    arg_q;
   logic [BYTE_W-1:0]   crc_q;
   logic [BYTE_W-1:0]   frame_byte;
   logic                byte_state;
   logic                xfer_done;
   logic                accept;
   logic                poll_last;
   logic                poll_inc;
   logic                answered;

   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign byte_state = (state_q == ST_CMD) || (state_q == ST_POLL) ||
                       (state_q == ST_TRAIL) || (state_q == ST_TAIL);
   assign xfer_done  = wait_q && spi_done;
   assign answered   = !spi_rx[BYTE_W-1];
   assign poll_inc   = (state_q == ST_POLL) && xfer_done && !answered;

   sd_cmd_framer i_framer (
      .idx    (idx_q),
      .arg    (arg_q),
      .crc    (crc_q),
      .sel    (bidx_q),
      .byte_o (frame_byte)
   );

   sd_poll_limit #(.LIMIT(POLL_LIMIT)) i_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q != ST_POLL),
      .inc   (poll_inc),
      .last  (poll_last)
   );

   if (TRAIL_EN) begin : g_trail
      sd_trail_shift #(.NBYTES(TRAIL_BYTES)) i_trail (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (accept),
         .shift ((state_q == ST_TRAIL) && xfer_done),
         .din   (spi_rx),
         .word  (rsp_trail)
      );
   end else begin : g_no_trail
      assign rsp_trail = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wait_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         keep_q  <= 1'b0;
         trl_q   <= 1'b0;
         tout_q  <= 1'b0;
         r1_q    <= FILL_BYTE;
         bidx_q  <= '0;
         idx_q   <= '0;
         arg_q   <= '0;
         crc_q   <= '0;
      end else begin
         if (spi_start) begin
            wait_q <= 1'b1;
         end else if (xfer_done) begin
            wait_q <= 1'b0;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  idx_q   <= req_index;
                  arg_q   <= req_arg;
                  crc_q   <= req_crc;
                  keep_q  <= req_keep_sel;
                  trl_q   <= req_trailer && TRAIL_EN;
                  tout_q  <= 1'b0;
                  r1_q    <= FILL_BYTE;
                  bidx_q  <= '0;
                  cs_n_q  <= 1'b0;
                  state_q <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (xfer_done) begin
                  if (bidx_q == LAST_FRAME) begin
                     state_q <= ST_POLL;
                  end else begin
                     bidx_q <= bidx_q + 1'b1;
                  end
               end
            end
            ST_POLL: begin
               if (xfer_done) begin
                  if (answered) begin
                     r1_q <= spi_rx;
                     if (trl_q) begin
                        bidx_q  <= '0;
                        state_q <= ST_TRAIL;
                     end else if (keep_q) begin
                        state_q <= ST_END;
                     end else begin
                        cs_n_q  <= 1'b1;
                        state_q <= ST_TAIL;
                     end
                  end else if (poll_last) begin
                     tout_q  <= 1'b1;
                     cs_n_q  <= 1'b1;
                     state_q <= ST_TAIL;
                  end
               end
            end
            ST_TRAIL: begin
               if (xfer_done) begin
                  if (bidx_q == LAST_TRAIL) begin
                     if (keep_q) begin
                        state_q <= ST_END;
                     end else begin
                        cs_n_q  <= 1'b1;
                        state_q <= ST_TAIL;
                     end
                  end else begin
                     bidx_q <= bidx_q + 1'b1;
                  end
               end
            end
            ST_TAIL: begin
               if (xfer_done) begin
                  state_q <= ST_END;
               end
            end
            ST_END: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_start   = byte_state && !wait_q;
   assign spi_tx      = (state_q == ST_CMD) ? frame_byte : FILL_BYTE;
   assign spi_cs_n    = cs_n_q;
   assign req_ready   = (state_q == ST_IDLE);
   assign rsp_done    = (state_q == ST_END);
   assign rsp_r1      = r1_q;
   assign rsp_timeout = tout_q;
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic spi_start,
   input logic spi_done,
   input logic spi_cs_n,
   input logic rsp_done
);
   logic out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (spi_start) begin
         out_q <= 1'b1;
      end else if (spi_done) begin
         out_q <= 1'b0;
      end
   end

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |=> !spi_start); // R9
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !out_q); // R9
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R8
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> req_ready); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R6
   AST_SELECT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> !req_ready); // R2
endmodule

bind sd_cmd_engine sd_cmd_engine_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .spi_start (spi_start),
   .spi_done  (spi_done),
   .spi_cs_n  (spi_cs_n),
   .rsp_done  (rsp_done)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
   localparam int LIMIT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [5:0]  req_index = '0;
   logic [31:0] req_arg = '0;
   logic [7:0]  req_crc = '0;
   logic        req_trailer = 1'b0;
   logic        req_keep_sel = 1'b0;
   logic [7:0]  spi_tx;
   logic        spi_start;
   logic        spi_done = 1'b0;
   logic [7:0]  spi_rx = 8'hFF;
   logic        spi_cs_n;
   logic        rsp_done;
   logic [7:0]  rsp_r1;
   logic [31:0] rsp_trail;
   logic        rsp_timeout;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   logic [7:0] script [0:31];
   logic [7:0] tx_log [0:31];
   logic       cs_log [0:31];
   int         nbytes = 0;
   bit         m_busy = 1'b0;
   int         m_dly = 0;

   always #2.5 clk = ~clk;

   sd_cmd_engine #(.POLL_LIMIT(LIMIT), .TRAIL_EN(1'b1)) i_sd_cmd_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_index(req_index), .req_arg(req_arg), .req_crc(req_crc),
      .req_trailer(req_trailer), .req_keep_sel(req_keep_sel),
      .spi_tx(spi_tx), .spi_start(spi_start), .spi_done(spi_done),
      .spi_rx(spi_rx), .spi_cs_n(spi_cs_n), .rsp_done(rsp_done),
      .rsp_r1(rsp_r1), .rsp_trail(rsp_trail), .rsp_timeout(rsp_timeout)
   );

   // byte-level SPI master model
   always @(negedge clk) begin
      cycles++;
      spi_done = 1'b0;
      if (m_busy) begin
         if (m_dly == 0) begin
            spi_rx = (nbytes <= 32) ? script[nbytes-1] : 8'hFF;
            spi_done = 1'b1;
            m_busy = 1'b0;
         end else begin
            m_dly--;
         end
      end else if (spi_start) begin
         if (nbytes < 32) begin
            tx_log[nbytes] = spi_tx;
            cs_log[nbytes] = spi_cs_n;
         end
         nbytes++;
         m_busy = 1'b1;
         m_dly = 1;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic clear_script();
      for (int k = 0; k < 32; k++) begin
         script[k] = 8'hFF;
         tx_log[k] = 8'h00;
         cs_log[k] = 1'b0;
      end
      nbytes = 0;
   endtask

   // issue a request and wait for done; ready must drop after acceptance
   task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                          input logic [7:0] crc, input bit trl, input bit keep,
                          input bit jam);
      int wd;
      @(negedge clk);
      req_index = idx; req_arg = arg; req_crc = crc;
      req_trailer = trl; req_keep_sel = keep; req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 ready low after accept", 32'(req_ready), 32'h0);
      if (jam) begin
         req_index = 6'h3F; req_arg = 32'hDEADBEEF;
      end else begin
         req_valid = 1'b0;
      end
      wd = 0;
      while (rsp_done !== 1'b1 && wd < 2000) begin
         @(negedge clk);
         wd++;
      end
      req_valid = 1'b0;
      chk(wd < 2000, "R6 done reached", 32'(wd), 32'd2000);
   endtask

   task automatic chk_frame(input logic [5:0] idx, input logic [31:0] arg,
                            input logic [7:0] crc);
      logic [7:0] exp [0:5];
      exp[0] = 8'h40 | {2'b00, idx};
      exp[1] = arg[31:24]; exp[2] = arg[23:16];
      exp[3] = arg[15:8];  exp[4] = arg[7:0];
      exp[5] = crc;
      for (int k = 0; k < 6; k++) begin
         chk(tx_log[k] == exp[k], $sformatf("R1 frame byte %0d", k),
             32'(tx_log[k]), 32'(exp[k]));
         chk(cs_log[k] == 1'b0, $sformatf("R2 cs low on frame byte %0d", k),
             32'(cs_log[k]), 32'h0);
      end
   endtask

   task automatic chk_release(input int total);
      chk(nbytes == total, "R6 byte count", 32'(nbytes), 32'(total));
      chk(tx_log[total-1] == 8'hFF && cs_log[total-1] == 1'b1,
          "R6 release byte sent with cs high",
          {23'd0, cs_log[total-1], tx_log[total-1]}, 32'h1FF);
      for (int k = 6; k < total - 1; k++) begin
         chk(cs_log[k] == 1'b0 && tx_log[k] == 8'hFF,
             $sformatf("R2 R3 cs low, 0xFF sent on byte %0d", k),
             {23'd0, cs_log[k], tx_log[k]}, 32'h0FF);
      end
      chk(spi_cs_n == 1'b1, "R6 cs high at done", 32'(spi_cs_n), 32'h1);
   endtask

   task automatic t_reset();
      chk(spi_cs_n == 1'b1, "R10 cs after reset", 32'(spi_cs_n), 32'h1);
      chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);
      chk(rsp_done == 1'b0, "R10 done after reset", 32'(rsp_done), 32'h0);
      chk(spi_start == 1'b0, "R10 start after reset", 32'(spi_start), 32'h0);
   endtask

   task automatic t_trailer();
      clear_script();
      script[6] = 8'hFF; script[7] = 8'h01;
      script[8] = 8'h00; script[9] = 8'h00; script[10] = 8'h01; script[11] = 8'hAA;
      run_cmd(6'd8, 32'h000001AA, 8'h87, 1'b1, 1'b0, 1'b0);
      chk_frame(6'd8, 32'h000001AA, 8'h87);
      chk(rsp_r1 == 8'h01, "R3 status with trailer", 32'(rsp_r1), 32'h01);
      chk(rsp_trail == 32'h000001AA, "R5 trailer word", rsp_trail, 32'h000001AA);
      chk(rsp_timeout == 1'b0, "R4 no timeout", 32'(rsp_timeout), 32'h0);
      chk_release(13);
   endtask

   task automatic t_basic();
      clear_script();
      script[6] = 8'hFF; script[7] = 8'hFE; script[8] = 8'h01;
      run_cmd(6'd0, 32'h0, 8'h95, 1'b0, 1'b0, 1'b0);
      chk_frame(6'd0, 32'h0, 8'h95);
      chk(rsp_r1 == 8'h01, "R3 status after skipped bytes", 32'(rsp_r1), 32'h01);
      chk(rsp_trail == 32'h0, "R5 trailer zero when not requested", rsp_trail, 32'h0);
      chk_release(10);
   endtask

   task automatic t_arg_order();
      clear_script();
      script[6] = 8'h80; script[7] = 8'h04;
      run_cmd(6'd17, 32'h12345678, 8'h5A, 1'b0, 1'b0, 1'b0);
      chk_frame(6'd17, 32'h12345678, 8'h5A);
      chk(rsp_r1 == 8'h04, "R3 status 0x04", 32'(rsp_r1), 32'h04);
      chk_release(9);
   endtask

   task automatic t_last_poll();
      clear_script();
      script[6 + LIMIT - 1] = 8'h00;
      run_cmd(6'd55, 32'h0, 8'h01, 1'b0, 1'b0, 1'b0);
      chk(rsp_timeout == 1'b0, "R4 answer on last poll accepted",
          32'(rsp_timeout), 32'h0);
      chk(rsp_r1 == 8'h00, "R4 status on last poll", 32'(rsp_r1), 32'h00);
      chk_release(6 + LIMIT + 1);
   endtask

   task automatic t_timeout();
      clear_script();
      run_cmd(6'd41, 32'h40000000, 8'h01, 1'b0, 1'b0, 1'b0);
      chk(rsp_timeout == 1'b1, "R4 timeout flag", 32'(rsp_timeout), 32'h1);
      chk(rsp_r1 == 8'hFF, "R4 status on timeout", 32'(rsp_r1), 32'hFF);
      chk_release(6 + LIMIT + 1);
   endtask

   task automatic t_keep_ok();
      clear_script();
      script[6] = 8'h00;
      run_cmd(6'd24, 32'h00000200, 8'h01, 1'b0, 1'b1, 1'b0);
      chk(spi_cs_n == 1'b0, "R7 cs low at done in keep mode", 32'(spi_cs_n), 32'h0);
      chk(nbytes == 7, "R7 no release byte in keep mode", 32'(nbytes), 32'd7);
      repeat (10) @(negedge clk);
      chk(spi_cs_n == 1'b0 && nbytes == 7, "R7 cs held low while idle",
          {15'd0, spi_cs_n, 16'(nbytes)}, 32'd7);
   endtask

   task automatic t_keep_timeout();
      clear_script();
      run_cmd(6'd24, 32'h0, 8'h01, 1'b0, 1'b1, 1'b0);
      chk(rsp_timeout == 1'b1, "R7 keep-mode timeout flag", 32'(rsp_timeout), 32'h1);
      chk_release(6 + LIMIT + 1);
   endtask

   task automatic t_busy_ignore();
      clear_script();
      script[6] = 8'h05;
      run_cmd(6'd16, 32'h00000200, 8'hFF, 1'b0, 1'b0, 1'b1);
      repeat (20) @(negedge clk);
      chk(nbytes == 8, "R8 request during busy ignored", 32'(nbytes), 32'd8);
      chk(tx_log[0] == 8'h50, "R8 first command kept", 32'(tx_log[0]), 32'h50);
      chk(req_ready == 1'b1, "R8 ready back in idle", 32'(req_ready), 32'h1);
   endtask

   initial begin
      while (cycles < 100000) @(negedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      clear_script();
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_trailer();
      t_basic();
      t_arg_order();
      t_last_poll();
      t_timeout();
      t_keep_ok();
      t_keep_timeout();
      t_busy_ignore();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule